// File: doc/BRIEF.md
# GF(3^m) Progressive-Reduction Multiplier

This block multiplies two elements of the extension field GF(3^M) held in polynomial basis. The field is fixed by a trinomial x^M + qk·x^K + q0 whose low coefficients are supplied at run time. Operand A sits in a linear row of M trit cells. Operand B is fed in one trit per clock, most significant trit first. After each step the row shifts its accumulator up by one position. The trit that falls off the top is scaled and folded back into cell 0 and cell K. The running sum therefore never holds more than M trits, and no separate reduction pass is needed.

A one-cycle start strobe captures A, B, qk and q0. The multiplication then runs for exactly M clocks. A one-cycle done strobe marks the cycle in which the product is available on the parallel output. The product stays on that output until the next accepted start.

Top module: `gf3_ppr_mult`

## Requirements
- R1: prod_o equals A·B mod (x^M + qk·x^K + q0), computed over GF(3). Trit j of every vector sits at bits [2j+1:2j], coded 00=0, 01=1, 10=2. The block supports 0 < K < M, with qk in {1,2} and q0 in {1,2}.
- R2: A start accepted at clock edge E is followed by done_o high for exactly one cycle, the cycle after edge E+M. At that point prod_o holds the result.
- R3: busy_o is high from edge E up to edge E+M, and low in the done cycle.
- R4: A start that arrives while busy_o is high is ignored. The result and the done timing stay those of the operation already running.
- R5: A trit coded 11 on a_i or b_i counts as 0. If qk_i is coded 11, the feedback into cell K counts as 0.
- R6: After reset prod_o is all zero. When the block is idle, prod_o holds its last value until the next accepted start.
- R7: A start that arrives in the done cycle is accepted. A start held high continuously gives back-to-back operations of M+1 cycles each.
- R8: The same design gives correct products for (M,K) = (9,4), (23,3) and (31,5), with either value of qk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a multiplication; the operands are sampled on this edge |
| a_i | input | 2*M | Operand A, M trits |
| b_i | input | 2*M | Operand B, M trits |
| qk_i | input | 2 | Trinomial coefficient of x^K |
| q0_i | input | 2 | Trinomial constant term |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle strobe: the product is valid |
| prod_o | output | 2*M | Product, M trits |

## Verification
A wrong trit in any accumulator cell stays hidden until done_o, which comes M cycles after start. At that point it shows as a wrong product trit. If the fault was in the top cell, it spreads through the feedback into trits 0 and K, and then upward. A fault in the control counter shows at once as busy_o or done_o changing on the wrong cycle. This is visible because the bench compares both strobes on every clock against a timing model. A failure to clear or to hold the accumulators shows as a changed prod_o while the block is idle, and the bench also compares prod_o on every idle cycle.

// File: rtl/gf3_pkg.sv
package gf3_pkg;
  typedef logic [1:0] trit_t;

  // code 11 or 00 on either side gives 0
  function automatic trit_t t_mul(trit_t x, trit_t y);
    if (x == 2'd0 || y == 2'd0 || x == 2'd3 || y == 2'd3) return 2'd0;
    return (x == y) ? 2'd1 : 2'd2;
  endfunction

  function automatic trit_t t_add(trit_t x, trit_t y);
    logic [2:0] s;
    trit_t xv, yv;
    xv = (x == 2'd3) ? 2'd0 : x;
    yv = (y == 2'd3) ? 2'd0 : y;
    s  = {1'b0, xv} + {1'b0, yv};
    return (s >= 3'd3) ? trit_t'(s - 3'd3) : s[1:0];
  endfunction

  function automatic trit_t t_neg(trit_t x);
    return t_mul(2'd2, x);
  endfunction
endpackage

// File: rtl/gf3_seq_ctrl.sv
module gf3_seq_ctrl #(
  parameter int M = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(M + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q, last;

  assign load_o = start_i & ~busy_q;
  assign step_o = busy_q;
  assign last   = (cnt_q == CW'(M - 1));
  assign busy_o = busy_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (load_o) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
      busy_q <= ~last;
      done_q <= last;
    end else begin
      done_q <= 1'b0;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));
  // R3
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
endmodule

// File: rtl/gf3_bcast.sv
module gf3_bcast
  import gf3_pkg::*;
#(
  parameter int M = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [2*M-1:0] b_i,
  output trit_t        b_cur_o
);
  logic [2*M-1:0] b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      b_q <= '0;
    else if (load_i)  b_q <= b_i;
    else if (step_i)  b_q <= {b_q[2*M-3:0], 2'b00};
  end

  // most significant remaining trit goes to every cell
  assign b_cur_o = b_q[2*M-1 -: 2];
endmodule

// File: rtl/gf3_pe.sv
module gf3_pe
  import gf3_pkg::*;
#(
  parameter bit HAS_FB = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  logic  step_i,
  input  trit_t a_i,
  input  trit_t b_i,
  input  trit_t c_i,
  input  trit_t fb_i,
  input  trit_t nq_i,
  output trit_t c_o
);
  trit_t a_q, c_q, fb_term, c_next;

  generate
    if (HAS_FB) begin : g_fb
      trit_t nq_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     nq_q <= 2'd0;
        else if (load_i) nq_q <= nq_i;
      end
      assign fb_term = t_mul(nq_q, fb_i);
    end else begin : g_plain
      logic unused_fb;
      assign unused_fb = ^{fb_i, nq_i};
      assign fb_term   = 2'd0;
    end
  endgenerate

  assign c_next = t_add(t_add(c_i, t_mul(b_i, a_q)), fb_term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 2'd0;
      c_q <= 2'd0;
    end else if (load_i) begin
      a_q <= a_i;
      c_q <= 2'd0;
    end else if (step_i) begin
      c_q <= c_next;
    end
  end

  assign c_o = c_q;

  // R4
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> $stable(a_q));
endmodule

// File: rtl/gf3_ppr_mult.sv
module gf3_ppr_mult
  import gf3_pkg::*;
#(
  parameter int M = 9,
  parameter int K = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [2*M-1:0] a_i,
  input  logic [2*M-1:0] b_i,
  input  logic [1:0]     qk_i,
  input  logic [1:0]     q0_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [2*M-1:0] prod_o
);
  logic  load, step;
  trit_t b_cur, nq0, nqk;
  trit_t c_w [M];

  gf3_seq_ctrl #(.M(M)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .load_o(load), .step_o(step), .busy_o, .done_o
  );

  gf3_bcast #(.M(M)) u_bcast (
    .clk_i, .rst_ni, .load_i(load), .step_i(step), .b_i, .b_cur_o(b_cur)
  );

  assign nq0 = t_neg(q0_i);
  assign nqk = t_neg(qk_i);

  generate
    for (genvar j = 0; j < M; j++) begin : g_cell
      trit_t c_in;
      if (j == 0) begin : g_low
        assign c_in = 2'd0;
      end else begin : g_up
        assign c_in = c_w[j-1];
      end
      gf3_pe #(.HAS_FB((j == 0) || (j == K))) u_pe (
        .clk_i, .rst_ni,
        .load_i(load), .step_i(step),
        .a_i(a_i[2*j +: 2]), .b_i(b_cur), .c_i(c_in),
        .fb_i(c_w[M-1]), .nq_i((j == 0) ? nq0 : nqk),
        .c_o(c_w[j])
      );
      assign prod_o[2*j +: 2] = c_w[j];
    end
  endgenerate

  // R6
  prod_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(prod_o));
endmodule

// File: tb/sim_gf3_ppr_mult.sv
`timescale 1ns/1ps
module sim_gf3_ppr_mult;
  localparam int NL = 3;
  localparam int LM [NL] = '{9, 23, 31};
  localparam int LK [NL] = '{4, 3, 5};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [61:0] a_all = '0, b_all = '0;
  logic [1:0]  qk = 2'd2, q0 = 2'd1;
  logic        busy [NL], done [NL];
  logic [61:0] prod [NL];
  logic [17:0] p0;
  logic [45:0] p1;
  logic [61:0] p2;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  gf3_ppr_mult #(.M(9), .K(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_all[17:0]), .b_i(b_all[17:0]),
    .qk_i(qk), .q0_i(q0), .busy_o(busy[0]), .done_o(done[0]), .prod_o(p0));
  gf3_ppr_mult #(.M(23), .K(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_all[45:0]), .b_i(b_all[45:0]),
    .qk_i(qk), .q0_i(q0), .busy_o(busy[1]), .done_o(done[1]), .prod_o(p1));
  gf3_ppr_mult #(.M(31), .K(5)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .a_i(a_all), .b_i(b_all),
    .qk_i(qk), .q0_i(q0), .busy_o(busy[2]), .done_o(done[2]), .prod_o(p2));

  assign prod[0] = {44'b0, p0};
  assign prod[1] = {16'b0, p1};
  assign prod[2] = p2;

  function automatic int tv(logic [1:0] t);
    return (t == 2'd3) ? 0 : int'(t);
  endfunction

  // schoolbook product, then fold x^m -> -qk x^k - q0 from the top down
  function automatic logic [61:0] ref_mul(int m, int k, logic [61:0] a, logic [61:0] b,
                                          logic [1:0] cqk, logic [1:0] cq0);
    int g [64];
    int nk, n0, t;
    logic [61:0] r;
    for (int i = 0; i < 64; i++) g[i] = 0;
    for (int i = 0; i < m; i++)
      for (int j = 0; j < m; j++)
        g[i+j] = (g[i+j] + tv(a[2*i +: 2]) * tv(b[2*j +: 2])) % 3;
    nk = (3 - tv(cqk)) % 3;
    n0 = (3 - tv(cq0)) % 3;
    for (int d = 2*m - 2; d >= m; d--) begin
      t = g[d];
      g[d] = 0;
      g[d-m+k] = (g[d-m+k] + nk * t) % 3;
      g[d-m]   = (g[d-m] + n0 * t) % 3;
    end
    r = '0;
    for (int i = 0; i < m; i++) r[2*i +: 2] = 2'(g[i]);
    return r;
  endfunction

  // timing and value model per lane
  bit          m_busy [NL], m_done [NL];
  int          m_cnt  [NL];
  logic [61:0] m_exp  [NL];

  always @(posedge clk or negedge rst_n) begin
    for (int l = 0; l < NL; l++) begin
      if (!rst_n) begin
        m_busy[l] = 0; m_done[l] = 0; m_cnt[l] = 0; m_exp[l] = '0;
      end else if (start && !m_busy[l]) begin
        m_busy[l] = 1; m_done[l] = 0; m_cnt[l] = 0;
        m_exp[l] = ref_mul(LM[l], LK[l], a_all, b_all, qk, q0);
      end else if (m_busy[l]) begin
        m_cnt[l]++;
        if (m_cnt[l] == LM[l]) begin
          m_busy[l] = 0; m_done[l] = 1;
        end
      end else begin
        m_done[l] = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, int lane, logic [61:0] act, logic [61:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s lane %0d: actual %h expected %h at %0t", req, lane, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int l = 0; l < NL; l++) begin
        chk(done[l] == m_done[l], "R2 done", l, 62'(done[l]), 62'(m_done[l]));
        chk(busy[l] == m_busy[l], "R3 busy", l, 62'(busy[l]), 62'(m_busy[l]));
        if (!m_busy[l])
          chk(prod[l] == m_exp[l], m_done[l] ? cur_tag : "R6", l, prod[l], m_exp[l]);
      end
    end
  end

  function automatic logic [61:0] rnd_trits();
    logic [61:0] v;
    for (int i = 0; i < 31; i++) v[2*i +: 2] = 2'($urandom % 3);
    return v;
  endfunction

  task automatic run_op(logic [61:0] a, logic [61:0] b, logic [1:0] cqk, logic [1:0] cq0);
    @(negedge clk);
    a_all = a; b_all = b; qk = cqk; q0 = cq0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R6 reset state
    for (int l = 0; l < NL; l++) begin
      chk(prod[l] == '0, "R6 reset", l, prod[l], '0);
      chk(done[l] == 1'b0 && busy[l] == 1'b0, "R3 reset", l, 62'({busy[l], done[l]}), '0);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    cur_tag = "R1";
    run_op('0, rnd_trits(), 2'd2, 2'd1);
    run_op(62'b01, rnd_trits(), 2'd2, 2'd1);
    run_op(rnd_trits(), 62'b01, 2'd2, 2'd1);
    run_op({31{2'b10}}, {31{2'b10}}, 2'd2, 2'd1);
    run_op({31{2'b10}}, {31{2'b10}}, 2'd1, 2'd2);

    cur_tag = "R8";
    for (int n = 0; n < 12; n++)
      run_op(rnd_trits(), rnd_trits(), 2'(1 + ($urandom % 2)), 2'(1 + ($urandom % 2)));

    cur_tag = "R5";
    run_op({31{2'b11}}, rnd_trits(), 2'd2, 2'd1);
    for (int n = 0; n < 4; n++)
      run_op({$urandom, $urandom}, {$urandom, $urandom}, 2'd2, 2'd1);
    run_op(rnd_trits(), rnd_trits(), 2'd3, 2'd1);

    // R4 start while busy: second strobe must be dropped
    cur_tag = "R4";
    @(negedge clk);
    a_all = rnd_trits(); b_all = rnd_trits(); qk = 2'd2; q0 = 2'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    a_all = rnd_trits(); b_all = rnd_trits(); qk = 2'd1; q0 = 2'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (34) @(negedge clk);

    // R7 start held high: back-to-back operations
    cur_tag = "R7";
    a_all = rnd_trits(); b_all = rnd_trits(); start = 1'b1;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      a_all = rnd_trits(); b_all = rnd_trits();
    end
    start = 1'b0;
    repeat (34) @(negedge clk);

    summary();
  end
endmodule